// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder

This block sits between the digital control inputs of a full-bridge motor driver and the gate drivers of its four switches. Each clock cycle it decodes a standby input, a fault-disable input, a direction input, an enable input, a decay-mode input, a current-over-limit flag and a zero-current flag into a requested state for each bridge leg: high switch on, low switch on, or both off (high impedance). A per-leg sequencer then applies that request to the gates. Switching off is immediate. Switching on waits until the leg has been fully off for a programmable dead time, so the two switches of a leg can never conduct together.

With enable high the bridge drives the motor in the direction selected. With enable low the mode input picks either a brake that turns on both high switches, or fast decay with synchronous rectification, which reverses the drive of both legs until the zero-current flag releases the bridge to high impedance. When a separate current regulator raises the over-limit flag during drive, the bridge runs a mixed decay: a fixed number of cycles of reversed drive, then brake, for as long as the flag stays high.

Top module: `hbridge_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, every gate output is 0 and hiz_o is 2'b11.
- R2: One clock edge after stby_ni is sampled low, all gates are off and hiz_o is 2'b11, whatever the other inputs are.
- R3: One clock edge after fault_dis_i is sampled high, all gates are off and hiz_o is 2'b11. Standby is the only input that takes priority over it.
- R4: With stby_ni=1, fault_dis_i=0, en_i=1 and ovr_lim_i=0, the requested drive is: dir_i=1 gives leg 0 high and leg 1 low; dir_i=0 gives leg 0 low and leg 1 high. Bit 0 of every output vector is leg 0 and bit 1 is leg 1.
- R5: With en_i=0 and mode_i=1 (brake), both legs are requested high, whatever dir_i and zero_cur_i are, and no low-side gate is on.
- R6: With en_i=0 and mode_i=0 (fast decay), each leg is requested at the opposite of its R4 level for the present dir_i.
- R7: In fast decay (en_i=0, mode_i=0) with zero_cur_i=1, both legs go to high impedance one edge later.
- R8: With en_i=1 and ovr_lim_i=1, the first FAST_CYC cycles in which the flag is sampled high request the reversed drive of R6. Later cycles request both legs high until the flag falls. The count restarts whenever the flag, enable, standby or fault-disable leaves that condition.
- R9: A gate of a leg turns on only after that leg has shown both gates off for at least DEAD_CYC consecutive sampled cycles. A direct reversal of a leg therefore puts the opposite gate on exactly DEAD_CYC cycles after the first gate goes off.
- R10: hs_o[i] and ls_o[i] are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stby_ni | input | 1 | Active-low standby; low releases the whole bridge |
| fault_dis_i | input | 1 | Forces all gates off |
| dir_i | input | 1 | Direction select |
| en_i | input | 1 | Drive enable |
| mode_i | input | 1 | Decay select with enable low: 1 brake, 0 fast decay |
| ovr_lim_i | input | 1 | Current over limit, from the regulator |
| zero_cur_i | input | 1 | Load current near zero |
| hs_o | output | 2 | High-side gate enable per leg |
| ls_o | output | 2 | Low-side gate enable per leg |
| hiz_o | output | 2 | Leg in high impedance per leg |

## Verification
The hardest state to reach is the brake part of a mixed-decay chop. It needs the over-limit flag held through FAST_CYC reversed cycles and the dead-time gaps on both legs, with no change on any other input. The random stimulus holds each input pattern for up to 20 cycles and raises the over-limit flag often, so that the fast-to-brake handover shows up many times. A directed reversal measures the off gap of leg 0 in cycles.

// File: rtl/hb_ctrl_pkg.sv
package hb_ctrl_pkg;
  localparam int NUM_LEGS = 2;

  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_drive_e;
endpackage

// File: rtl/hb_mode_dec.sv
module hb_mode_dec
  import hb_ctrl_pkg::*;
#(
  parameter int FAST_CYC = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       stby_ni,
  input  logic                       fault_dis_i,
  input  logic                       dir_i,
  input  logic                       en_i,
  input  logic                       mode_i,
  input  logic                       ovr_lim_i,
  input  logic                       zero_cur_i,
  output leg_drive_e [NUM_LEGS-1:0]  tgt_o
);
  localparam int CW = $clog2(FAST_CYC + 1);

  logic [CW-1:0] chop_q;
  logic          chop_act;
  logic          fast_phase;

  assign chop_act   = stby_ni && !fault_dis_i && en_i && ovr_lim_i;
  assign fast_phase = chop_q < CW'(FAST_CYC);

  // counts sampled over-limit cycles, saturating at FAST_CYC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              chop_q <= '0;
    else if (!chop_act)       chop_q <= '0;
    else if (fast_phase)      chop_q <= chop_q + CW'(1);
  end

  always_comb begin
    for (int l = 0; l < NUM_LEGS; l++) begin
      logic       fwd_hi;
      leg_drive_e fwd, rev;
      fwd_hi = dir_i ^ (l == 1);
      fwd    = fwd_hi ? LEG_HI : LEG_LO;
      rev    = fwd_hi ? LEG_LO : LEG_HI;
      if (!stby_ni || fault_dis_i)  tgt_o[l] = LEG_OFF;
      else if (en_i && !ovr_lim_i)  tgt_o[l] = fwd;
      else if (en_i)                tgt_o[l] = fast_phase ? rev : LEG_HI;
      else if (mode_i)              tgt_o[l] = LEG_HI;
      else if (zero_cur_i)          tgt_o[l] = LEG_OFF;
      else                          tgt_o[l] = rev;
    end
  end

  AST_CHOP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chop_q <= CW'(FAST_CYC)) else $error("chop counter overrun"); // R8
  AST_CHOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_lim_i |=> chop_q == '0) else $error("chop count not cleared"); // R8
endmodule

// File: rtl/hb_leg_gate.sv
module hb_leg_gate
  import hb_ctrl_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  leg_drive_e tgt_i,
  output logic       hs_o,
  output logic       ls_o,
  output logic       hiz_o
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  leg_drive_e    cur_q;
  logic [CW-1:0] off_q;
  logic          must_off;

  assign must_off = (tgt_i == LEG_OFF) || (cur_q != LEG_OFF && tgt_i != cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LEG_OFF;
      off_q <= CW'(DEAD_CYC);
    end else if (must_off) begin
      cur_q <= LEG_OFF;
      if (cur_q != LEG_OFF)            off_q <= CW'(1);
      else if (off_q < CW'(DEAD_CYC))  off_q <= off_q + CW'(1);
    end else if (cur_q == LEG_OFF) begin
      if (off_q >= CW'(DEAD_CYC))      cur_q <= tgt_i;
      else                             off_q <= off_q + CW'(1);
    end
  end

  assign hs_o  = cur_q == LEG_HI;
  assign ls_o  = cur_q == LEG_LO;
  assign hiz_o = cur_q == LEG_OFF;

  // independent run length of observed off cycles
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= CW'(DEAD_CYC);
    else if (hs_o || ls_o)           gap_q <= '0;
    else if (gap_q < CW'(DEAD_CYC))  gap_q <= gap_q + CW'(1);
  end

  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o)) else $error("shoot-through"); // R10
  AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hs_o || ls_o) && !$past(hs_o || ls_o)) |-> gap_q >= CW'(DEAD_CYC))
    else $error("dead time short"); // R9
  AST_OFF_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i == LEG_OFF) |=> hiz_o) else $error("leg not released"); // R2
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_ctrl_pkg::*;
#(
  parameter int DEAD_CYC = 4,
  parameter int FAST_CYC = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stby_ni,
  input  logic                fault_dis_i,
  input  logic                dir_i,
  input  logic                en_i,
  input  logic                mode_i,
  input  logic                ovr_lim_i,
  input  logic                zero_cur_i,
  output logic [NUM_LEGS-1:0] hs_o,
  output logic [NUM_LEGS-1:0] ls_o,
  output logic [NUM_LEGS-1:0] hiz_o
);
  leg_drive_e [NUM_LEGS-1:0] tgt;

  hb_mode_dec #(.FAST_CYC(FAST_CYC)) u_dec (
    .clk_i, .rst_ni, .stby_ni, .fault_dis_i, .dir_i, .en_i, .mode_i,
    .ovr_lim_i, .zero_cur_i, .tgt_o(tgt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hb_leg_gate #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i, .rst_ni, .tgt_i(tgt[g]),
      .hs_o(hs_o[g]), .ls_o(ls_o[g]), .hiz_o(hiz_o[g])
    );
  end

  AST_STBY_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_ni |=> (&hiz_o && hs_o == '0 && ls_o == '0)) else $error("standby"); // R2
  AST_FAULT_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_dis_i |=> (&hiz_o && hs_o == '0 && ls_o == '0)) else $error("fault"); // R3
  AST_BRAKE_NO_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_ni && !fault_dis_i && !en_i && mode_i) |=> ls_o == '0) else $error("brake"); // R5
  AST_FWD_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_ni && !fault_dis_i && en_i && !ovr_lim_i && dir_i) |=> (!hs_o[1] && !ls_o[0]))
    else $error("forward"); // R4
  AST_ZERO_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_ni && !fault_dis_i && !en_i && !mode_i && zero_cur_i) |=> &hiz_o)
    else $error("zero current"); // R7
endmodule

// File: tb/hbridge_ctrl_tb_top.sv
`timescale 1ns/1ps
module hbridge_ctrl_tb_top;
  localparam int DEAD = 4;
  localparam int FAST = 6;

  logic clk = 0, rst_n = 0;
  logic stby_n = 0, fdis = 0, dir = 0, en = 0, mode = 0, ovr = 0, zero = 0;
  logic [1:0] hs, ls, hiz;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hbridge_ctrl #(.DEAD_CYC(DEAD), .FAST_CYC(FAST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stby_ni(stby_n), .fault_dis_i(fdis),
    .dir_i(dir), .en_i(en), .mode_i(mode), .ovr_lim_i(ovr), .zero_cur_i(zero),
    .hs_o(hs), .ls_o(ls), .hiz_o(hiz)
  );

  // requested leg state: 0 off, 1 high, 2 low
  function automatic int req_f(int leg, int chop);
    int fwd, rev;
    fwd = ((dir ^ (leg == 1)) != 0) ? 1 : 2;
    rev = 3 - fwd;
    if (!stby_n || fdis) return 0;
    if (en && !ovr)      return fwd;
    if (en)              return (chop < FAST) ? rev : 1;
    if (mode)            return 1;
    if (zero)            return 0;
    return rev;
  endfunction

  function automatic string tag_f();
    if (!stby_n) return "R2";
    if (fdis)    return "R3";
    if (en && !ovr) return "R4";
    if (en)      return "R8";
    if (mode)    return "R5";
    if (zero)    return "R7";
    return "R6";
  endfunction

  // reference: state per leg plus run of off cycles
  int m_st[2], m_run[2], m_chop;
  string m_tag = "R1";
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin m_st[l] = 0; m_run[l] = DEAD; end
      m_chop = 0; m_tag = "R1";
    end else begin
      for (int l = 0; l < 2; l++) begin
        int r;
        r = req_f(l, m_chop);
        if (m_st[l] != 0) begin
          if (r != m_st[l]) begin m_st[l] = 0; m_run[l] = 1; end
        end else if (r != 0 && m_run[l] >= DEAD) m_st[l] = r;
        else if (m_run[l] < DEAD) m_run[l]++;
      end
      if (stby_n && !fdis && en && ovr) begin
        if (m_chop < FAST) m_chop++;
      end else m_chop = 0;
      m_tag = tag_f();
    end
  end

  task automatic cmp();
    logic [1:0] eh, el, ez;
    for (int l = 0; l < 2; l++) begin
      eh[l] = m_st[l] == 1; el[l] = m_st[l] == 2; ez[l] = m_st[l] == 0;
    end
    checks++;
    if (hs !== eh || ls !== el || hiz !== ez) begin
      fails++;
      $display("FAIL %s hs=%b ls=%b hiz=%b exp hs=%b ls=%b hiz=%b", m_tag, hs, ls, hiz, eh, el, ez);
    end
    checks++;
    if ((hs & ls) != 2'b00) begin
      fails++;
      $display("FAIL R10 hs=%b ls=%b exp overlap=00", hs, ls);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); cmp(); end
  endtask

  initial begin
    int seed, gap;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    dir = 1; en = 1;
    #5;
    checks++;  // R1 during reset
    if (hs !== 2'b00 || ls !== 2'b00 || hiz !== 2'b11) begin
      fails++; $display("FAIL R1 hs=%b ls=%b hiz=%b exp 00 00 11", hs, ls, hiz);
    end
    @(negedge clk); rst_n = 1;
    step(1);
    stby_n = 1;
    step(DEAD + 4);
    // R9 directed reversal of leg 0
    dir = 0; gap = 0;
    @(negedge clk); cmp();
    while (ls[0] !== 1'b1 && gap < 50) begin
      if (hs[0] === 1'b0) gap++;
      @(negedge clk); cmp();
    end
    checks++;
    if (gap != DEAD) begin
      fails++; $display("FAIL R9 off gap=%0d exp %0d", gap, DEAD);
    end
    // R2 standby overrides drive
    step(6); stby_n = 0; step(3); stby_n = 1; step(8);
    // R3 fault during brake
    en = 0; mode = 1; step(8); fdis = 1; step(3); fdis = 0;
    // R8 long chop
    en = 1; dir = 1; step(10); ovr = 1; step(FAST + 2 * DEAD + 6); ovr = 0; step(10);
    // R7 fast decay then zero current
    en = 0; mode = 0; step(10); zero = 1; step(4); zero = 0; step(8);
    for (int s = 0; s < 600; s++) begin
      stby_n = ($urandom % 10) != 0;
      fdis   = ($urandom % 10) == 0;
      dir    = $urandom % 2;
      en     = $urandom % 2;
      mode   = $urandom % 2;
      ovr    = ($urandom % 3) == 0;
      zero   = ($urandom % 4) == 0;
      step(1 + ($urandom % 20));
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule